// File: doc/BRIEF.md
# Streaming COBS Frame Decoder

This block undoes consistent overhead byte stuffing on a byte-wide stream. Encoded frames arrive on a valid/ready sink that carries a data byte, an end-of-frame flag and a one-bit error flag. Decoded frames leave on a matching source port. Each code byte N announces N-1 literal bytes. Those bytes are copied to the output. A zero is restored between two segments whenever the earlier segment's code was below 255.

The decoder keeps one decoded byte in a holding register. Because of this it always knows which byte is the last of a frame, and it can put the end flag and any error on that byte. It flags three kinds of malformed frame: a zero byte inside a frame, a segment cut short by the end of the frame, and a frame that arrives already marked bad. If a bad frame has no decoded byte left to carry the flag, the decoder sends a single zero byte with the end and error flags set.

A build parameter selects how frames end. In one setting the input end flag ends a frame. In the other, a zero byte on the input acts as the frame delimiter and the input end flag is ignored. A registered two-entry stage on the output lets the consumer stall on any cycle without losing throughput.

Top module: `cobs_unstuff`

## Requirements
- R1: While reset is high and in the cycle after it, `out_valid` is low. After reset `in_ready` is high.
- R2: After a code byte N (1..255), the next N-1 input bytes appear on `out_data` unchanged and in order.
- R3: When a segment with a code below 255 is followed in the same frame by another code byte, one 0x00 byte is emitted between the two segments.
- R4: A segment coded 255 (254 literal bytes) is never followed by an inserted zero.
- R5: No zero is emitted after the final segment of a frame. A frame made only of code 0x01 produces no output beat. The frame 0x01,0x01 produces exactly one beat, 0x00, with `out_last` high.
- R6: `out_last` is high on the final decoded byte of each frame and low on every other byte.
- R7: With the zero delimiter disabled, a 0x00 byte inside a frame is discarded and the frame is flagged: `out_err` is high on its last beat. `out_err` is never high without `out_last`.
- R8: If a frame ends before the current segment has delivered all N-1 bytes, the bytes already received are emitted and the last beat carries `out_err`.
- R9: `in_err` on the beat that ends a frame marks that decoded frame with `out_err` on its last beat.
- R10: A flagged frame that yields no decoded byte produces one beat with `out_data` = 0x00, `out_last` = 1 and `out_err` = 1.
- R11: With `ZERO_DELIM` = 1, a 0x00 input byte ends the frame and `in_last` has no effect. A delimiter that arrives while a segment is still incomplete flags the frame as in R8.
- R12: Under any pattern of `out_ready` and `in_valid` gaps, every decoded byte is delivered exactly once. While `out_valid` is high and `out_ready` is low, the output beat stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Encoded byte |
| in_valid | input | 1 | Encoded byte is present |
| in_ready | output | 1 | Decoder accepts the byte this cycle |
| in_last | input | 1 | Byte ends the frame (used only when `ZERO_DELIM` = 0) |
| in_err | input | 1 | Frame arrived bad; taken from the frame-ending beat |
| out_data | output | 8 | Decoded byte |
| out_valid | output | 1 | Decoded byte is present |
| out_ready | input | 1 | Consumer takes the byte this cycle |
| out_last | output | 1 | Final byte of the decoded frame |
| out_err | output | 1 | Decoded frame is malformed; only with `out_last` |

## Verification
The bench builds two instances side by side. The first uses `ZERO_DELIM` = 0, which brings the stray-zero error and end-flag framing within reach. The second uses `ZERO_DELIM` = 1, where the delimiter ends frames and random `in_last` pulses in mid-frame must have no effect. Both instances are checked against a software encoder. The payloads used are random, all-zero, lengths from 253 to 258 that cross the 255-code boundary, and hand-built malformed frames. Input gaps and output backpressure are random.

// File: rtl/cobs_unstuff_pkg.sv
`timescale 1ns / 1ps
package cobs_unstuff_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] FULL_CODE = {BYTE_W{1'b1}};

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        byte_t data;
        logic  last;
        logic  err;
    } beat_t;

    typedef enum logic [1:0] {
        ST_CODE  = 2'd0,
        ST_DATA  = 2'd1,
        ST_FLUSH = 2'd2
    } dec_state_e;

    // a segment shorter than the maximum implies a zero before the next one
    function automatic logic implies_zero(byte_t code);
        return code != FULL_CODE;
    endfunction
endpackage

// File: rtl/cobs_unstuff_core.sv
`timescale 1ns / 1ps
module cobs_unstuff_core
    import cobs_unstuff_pkg::*;
#(
    parameter bit ZERO_DELIM = 1'b0
) (
    input  logic  clk,
    input  logic  rst,
    input  byte_t in_data,
    input  logic  in_valid,
    output logic  in_ready,
    input  logic  in_last,
    input  logic  in_err,
    output beat_t dn_beat,
    output logic  dn_valid,
    input  logic  dn_ready
);
    dec_state_e state_q, state_d;
    byte_t      remain_q, remain_d;
    logic       full_q, full_d;
    logic       zdue_q, zdue_d;
    logic       err_q, err_d;
    logic       pv_q, pv_d;
    byte_t      pd_q, pd_d;

    logic  accept, is_zero, ends, produce;
    byte_t prod_byte;

    assign in_ready = (state_q != ST_FLUSH) && dn_ready;
    assign accept   = in_valid && in_ready;
    assign is_zero  = (in_data == '0);
    assign ends     = ZERO_DELIM ? is_zero : in_last;

    always_comb begin
        state_d   = state_q;
        remain_d  = remain_q;
        full_d    = full_q;
        zdue_d    = zdue_q;
        err_d     = err_q;
        pv_d      = pv_q;
        pd_d      = pd_q;
        produce   = 1'b0;
        prod_byte = '0;
        dn_valid  = 1'b0;
        dn_beat   = '0;
        if (state_q == ST_FLUSH) begin
            if (pv_q || err_q) begin
                dn_valid     = 1'b1;
                dn_beat.data = pv_q ? pd_q : '0;
                dn_beat.last = 1'b1;
                dn_beat.err  = err_q;
            end
            if (dn_ready || !(pv_q || err_q)) begin
                state_d  = ST_CODE;
                remain_d = '0;
                full_d   = 1'b0;
                zdue_d   = 1'b0;
                err_d    = 1'b0;
                pv_d     = 1'b0;
            end
        end else if (accept) begin
            if (is_zero) begin
                // in delimiter mode the zero only closes the frame
                if (!ZERO_DELIM) err_d = 1'b1;
            end else if (state_q == ST_CODE) begin
                if (zdue_q) begin
                    produce   = 1'b1;
                    prod_byte = '0;
                end
                remain_d = in_data - 1'b1;
                full_d   = (in_data == FULL_CODE);
                if (in_data == byte_t'(1)) begin
                    zdue_d  = 1'b1;
                    state_d = ST_CODE;
                end else begin
                    zdue_d  = 1'b0;
                    state_d = ST_DATA;
                end
            end else begin
                produce   = 1'b1;
                prod_byte = in_data;
                remain_d  = remain_q - 1'b1;
                if (remain_q == byte_t'(1)) begin
                    state_d = ST_CODE;
                    zdue_d  = !full_q;
                end
            end
            if (produce) begin
                if (pv_q) begin
                    dn_valid     = 1'b1;
                    dn_beat.data = pd_q;
                end
                pv_d = 1'b1;
                pd_d = prod_byte;
            end
            if (ends) begin
                if (state_d == ST_DATA) err_d = 1'b1;
                if (in_err) err_d = 1'b1;
                state_d = ST_FLUSH;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_CODE;
            remain_q <= '0;
            full_q   <= 1'b0;
            zdue_q   <= 1'b0;
            err_q    <= 1'b0;
            pv_q     <= 1'b0;
            pd_q     <= '0;
        end else begin
            state_q  <= state_d;
            remain_q <= remain_d;
            full_q   <= full_d;
            zdue_q   <= zdue_d;
            err_q    <= err_d;
            pv_q     <= pv_d;
            pd_q     <= pd_d;
        end
    end

    // R6: a frame that is closing leaves the flush state once the output has room
    a_r6_flush_exits: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FLUSH && dn_ready) |=> (state_q == ST_CODE));

    // R3: a pending zero only waits at a segment boundary
    a_r3_zero_due_at_boundary: assert property (@(posedge clk) disable iff (rst)
        zdue_q |-> (state_q != ST_DATA));

    // R4: a full segment never leaves a zero pending
    a_r4_full_no_zero: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DATA && full_q && remain_q == byte_t'(1) && accept && !is_zero)
        |=> !zdue_q);
endmodule

// File: rtl/cobs_unstuff_skid.sv
`timescale 1ns / 1ps
module cobs_unstuff_skid
    import cobs_unstuff_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  beat_t up_beat,
    input  logic  up_valid,
    output logic  up_ready,
    output beat_t dn_beat,
    output logic  dn_valid,
    input  logic  dn_ready
);
    beat_t main_q, spare_q;
    logic  mv_q, sv_q;

    assign up_ready = !sv_q;
    assign dn_beat  = main_q;
    assign dn_valid = mv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mv_q    <= 1'b0;
            sv_q    <= 1'b0;
            main_q  <= '0;
            spare_q <= '0;
        end else if (dn_ready || !mv_q) begin
            if (sv_q) begin
                main_q <= spare_q;
                mv_q   <= 1'b1;
                sv_q   <= 1'b0;
            end else begin
                mv_q <= up_valid;
                if (up_valid) main_q <= up_beat;
            end
        end else if (up_valid && !sv_q) begin
            spare_q <= up_beat;
            sv_q    <= 1'b1;
        end
    end

    a_r12_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (mv_q && !dn_ready) |=> (mv_q && $stable(main_q)));

    a_r12_spare_behind_main: assert property (@(posedge clk) disable iff (rst)
        sv_q |-> mv_q);

    a_r1_reset_empties: assert property (@(posedge clk)
        rst |=> (!mv_q && !sv_q));

    a_r7_err_with_last: assert property (@(posedge clk) disable iff (rst)
        (mv_q && main_q.err) |-> main_q.last);
endmodule

// File: rtl/cobs_unstuff.sv
`timescale 1ns / 1ps
module cobs_unstuff
    import cobs_unstuff_pkg::*;
#(
    parameter bit ZERO_DELIM = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic       in_last,
    input  logic       in_err,
    output logic [7:0] out_data,
    output logic       out_valid,
    input  logic       out_ready,
    output logic       out_last,
    output logic       out_err
);
    beat_t mid_beat, tail_beat;
    logic  mid_valid, mid_ready;

    cobs_unstuff_core #(.ZERO_DELIM(ZERO_DELIM)) u_core (
        .clk      (clk),
        .rst      (rst),
        .in_data  (in_data),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_last  (in_last),
        .in_err   (in_err),
        .dn_beat  (mid_beat),
        .dn_valid (mid_valid),
        .dn_ready (mid_ready)
    );

    cobs_unstuff_skid u_skid (
        .clk      (clk),
        .rst      (rst),
        .up_beat  (mid_beat),
        .up_valid (mid_valid),
        .up_ready (mid_ready),
        .dn_beat  (tail_beat),
        .dn_valid (out_valid),
        .dn_ready (out_ready)
    );

    assign out_data = tail_beat.data;
    assign out_last = tail_beat.last;
    assign out_err  = tail_beat.err;
endmodule

// File: tb/cobs_unstuff_bench.sv
`timescale 1ns / 1ps
module cobs_unstuff_bench;
    typedef logic [7:0] bq_t[$];
    typedef struct {
        logic [7:0] d;
        logic       l;
        logic       e;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [7:0] d_data = '0;
    logic d_last = 1'b0, d_err = 1'b0, v_a = 1'b0, v_b = 1'b0;
    logic rdy_a, rdy_b;
    logic [7:0] od_a, od_b;
    logic ov_a, ov_b, ol_a, ol_b, oe_a, oe_b;
    logic or_a = 1'b1, or_b = 1'b1;

    exp_t exp_a[$];
    exp_t exp_b[$];
    int checks = 0;
    int fails = 0;
    bit idle_on = 0;
    bit bp_on = 0;
    bit done = 0;

    cobs_unstuff #(.ZERO_DELIM(1'b0)) u_cobs_unstuff (
        .clk(clk), .rst(rst), .in_data(d_data), .in_valid(v_a), .in_ready(rdy_a),
        .in_last(d_last), .in_err(d_err), .out_data(od_a), .out_valid(ov_a),
        .out_ready(or_a), .out_last(ol_a), .out_err(oe_a)
    );

    cobs_unstuff #(.ZERO_DELIM(1'b1)) u_cobs_unstuff_zd (
        .clk(clk), .rst(rst), .in_data(d_data), .in_valid(v_b), .in_ready(rdy_b),
        .in_last(d_last), .in_err(d_err), .out_data(od_b), .out_valid(ov_b),
        .out_ready(or_b), .out_last(ol_b), .out_err(oe_b)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 190000);
        fails++;
        $display("FAIL watchdog: run hung, actual=running expected=finished");
        finish_run();
    end

    function automatic bq_t cobs_enc(bq_t p);
        bq_t enc;
        bq_t seg;
        int  code = 1;
        bit  nd = 1;
        foreach (p[i]) begin
            if (p[i] == 8'h00) begin
                enc.push_back(8'(code));
                enc = {enc, seg};
                seg = {};
                code = 1;
                nd = 1;
            end else begin
                seg.push_back(p[i]);
                code++;
                nd = 1;
                if (code == 255) begin
                    enc.push_back(8'(code));
                    enc = {enc, seg};
                    seg = {};
                    code = 1;
                    nd = 0;
                end
            end
        end
        if (nd) begin
            enc.push_back(8'(code));
            enc = {enc, seg};
        end
        return enc;
    endfunction

    function automatic bq_t rand_payload(int n, int zero_odds);
        bq_t p;
        for (int i = 0; i < n; i++)
            p.push_back(($urandom % zero_odds == 0) ? 8'h00 : 8'(($urandom % 255) + 1));
        return p;
    endfunction

    function automatic bq_t ramp_payload(int n);
        bq_t p;
        for (int i = 0; i < n; i++) p.push_back(8'((i % 255) + 1));
        return p;
    endfunction

    task automatic push_exp(bit to_b, logic [7:0] d, logic l, logic e, string tag);
        exp_t x;
        x.d = d; x.l = l; x.e = e; x.tag = tag;
        if (to_b) exp_b.push_back(x); else exp_a.push_back(x);
    endtask

    task automatic expect_payload(bit to_b, bq_t p, string tag);
        foreach (p[i]) push_exp(to_b, p[i], (i == p.size() - 1), 1'b0, tag);
    endtask

    task automatic drive_byte(logic [7:0] b, logic l, logic e, bit to_b);
        if (idle_on && ($urandom % 4) == 0) begin
            @(negedge clk);
            v_a = 1'b0; v_b = 1'b0;
        end
        @(negedge clk);
        d_data = b; d_last = l; d_err = e;
        v_a = !to_b; v_b = to_b;
        forever begin
            #1;
            if (to_b ? rdy_b : rdy_a) break;
            @(negedge clk);
        end
    endtask

    task automatic release_bus();
        @(negedge clk);
        v_a = 1'b0; v_b = 1'b0; d_last = 1'b0; d_err = 1'b0;
    endtask

    // frame on instance A: in_last marks the final byte
    task automatic send_a(bq_t enc, logic err_end);
        foreach (enc[i])
            drive_byte(enc[i], (i == enc.size() - 1), (i == enc.size() - 1) && err_end, 1'b0);
        release_bus();
    endtask

    // frame on instance B: zero delimiter, in_last toggled as noise
    task automatic send_b(bq_t enc, logic err_end, bit noise);
        foreach (enc[i])
            drive_byte(enc[i], noise && ($urandom % 3 == 0), 1'b0, 1'b1);
        drive_byte(8'h00, noise, err_end, 1'b1);
        release_bus();
    endtask

    task automatic drain();
        while (exp_a.size() != 0 || exp_b.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    task automatic check_beat(bit to_b, logic [7:0] d, logic l, logic e);
        exp_t x;
        checks++;
        if ((to_b ? exp_b.size() : exp_a.size()) == 0) begin
            fails++;
            $display("FAIL R5 unexpected beat on %s: actual=%h/%b/%b expected=none",
                     to_b ? "B" : "A", d, l, e);
            return;
        end
        x = to_b ? exp_b.pop_front() : exp_a.pop_front();
        if (d !== x.d || l !== x.l || e !== x.e) begin
            fails++;
            $display("FAIL %s on %s: actual data/last/err=%h/%b/%b expected=%h/%b/%b",
                     x.tag, to_b ? "B" : "A", d, l, e, x.d, x.l, x.e);
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            or_a = bp_on ? (($urandom % 3) != 0) : 1'b1;
            #1;
            if (!rst && ov_a && or_a) check_beat(1'b0, od_a, ol_a, oe_a);
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            or_b = bp_on ? (($urandom % 3) != 0) : 1'b1;
            #1;
            if (!rst && ov_b && or_b) check_beat(1'b1, od_b, ol_b, oe_b);
        end
    end

    initial begin
        bq_t p;
        repeat (4) @(negedge clk);
        #1;
        checks++;
        if (ov_a !== 1'b0 || ov_b !== 1'b0) begin
            fails++;
            $display("FAIL R1 valid in reset: actual=%b%b expected=00", ov_a, ov_b);
        end
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        checks++;
        if (ov_a !== 1'b0 || rdy_a !== 1'b1 || rdy_b !== 1'b1) begin
            fails++;
            $display("FAIL R1 after reset: actual valid=%b ready=%b%b expected valid=0 ready=11",
                     ov_a, rdy_a, rdy_b);
        end

        // R2: plain literal segment
        p = '{8'h11, 8'h22, 8'h33};
        expect_payload(0, p, "R2");
        send_a(cobs_enc(p), 1'b0);

        // R5: lone code 1 is empty, 1,1 is one zero
        send_a('{8'h01}, 1'b0);
        push_exp(0, 8'h00, 1'b1, 1'b0, "R5");
        send_a('{8'h01, 8'h01}, 1'b0);

        // R6: last flag on final decoded byte
        p = '{8'h7e, 8'h00};
        expect_payload(0, p, "R6");
        send_a(cobs_enc(p), 1'b0);

        // R3: inserted zeros between short segments
        p = '{8'haa, 8'h00, 8'hbb, 8'h00, 8'h00, 8'hcc};
        expect_payload(0, p, "R3");
        send_a(cobs_enc(p), 1'b0);
        for (int n = 1; n <= 6; n++) begin
            p = {};
            for (int i = 0; i < n; i++) p.push_back(8'h00);
            expect_payload(0, p, "R3");
            send_a(cobs_enc(p), 1'b0);
        end

        // R4: lengths around the full-segment boundary
        for (int n = 253; n <= 258; n++) begin
            p = ramp_payload(n);
            expect_payload(0, p, "R4");
            send_a(cobs_enc(p), 1'b0);
        end
        p = ramp_payload(254);
        p.push_back(8'h00);
        expect_payload(0, p, "R4");
        send_a(cobs_enc(p), 1'b0);
        drain();

        // R7: stray zero in the middle of a frame
        push_exp(0, 8'h41, 1'b0, 1'b0, "R7");
        push_exp(0, 8'h42, 1'b1, 1'b1, "R7");
        send_a('{8'h03, 8'h41, 8'h00, 8'h42}, 1'b0);

        // R8: truncated segment
        push_exp(0, 8'haa, 1'b0, 1'b0, "R8");
        push_exp(0, 8'hbb, 1'b1, 1'b1, "R8");
        send_a('{8'h05, 8'haa, 8'hbb}, 1'b0);

        // R9: incoming error flag
        push_exp(0, 8'haa, 1'b0, 1'b0, "R9");
        push_exp(0, 8'hbb, 1'b1, 1'b1, "R9");
        send_a('{8'h03, 8'haa, 8'hbb}, 1'b1);

        // R10: errored frames with nothing to carry the flag
        push_exp(0, 8'h00, 1'b1, 1'b1, "R10");
        send_a('{8'h00}, 1'b0);
        push_exp(0, 8'h00, 1'b1, 1'b1, "R10");
        send_a('{8'h01}, 1'b1);
        drain();

        // R12: random traffic with gaps and backpressure
        idle_on = 1;
        bp_on = 1;
        for (int k = 0; k < 24; k++) begin
            p = rand_payload(1 + ($urandom % 40), 6);
            expect_payload(0, p, "R12");
            send_a(cobs_enc(p), 1'b0);
        end
        p = rand_payload(300, 200);
        expect_payload(0, p, "R12");
        send_a(cobs_enc(p), 1'b0);
        p = '{8'h00, 8'h00, 8'h00};
        expect_payload(0, p, "R12");
        send_a(cobs_enc(p), 1'b0);
        drain();

        // R11: delimiter framing, in_last noise ignored
        for (int k = 0; k < 12; k++) begin
            p = rand_payload(1 + ($urandom % 30), 5);
            expect_payload(1, p, "R11");
            send_b(cobs_enc(p), 1'b0, 1'b1);
        end
        p = ramp_payload(256);
        expect_payload(1, p, "R11");
        send_b(cobs_enc(p), 1'b0, 1'b1);
        push_exp(1, 8'haa, 1'b1, 1'b1, "R11");
        send_b('{8'h04, 8'haa}, 1'b0, 1'b0);
        push_exp(1, 8'h55, 1'b1, 1'b1, "R11");
        send_b('{8'h02, 8'h55}, 1'b1, 1'b0);
        drain();

        finish_run();
    end
endmodule